// File: doc/BRIEF.md
# Transmit Phase-Align Elastic Buffer

This block carries 10-bit transmit characters from an interface clock into the internal character clock, which is taken to be the reference clock. A select input picks which clock writes the buffer: an external transmit clock, or the reference clock itself. The external clock must run at the character rate, but its phase relative to the reference clock may be anything. The buffer absorbs that offset, and also up to half a character of later drift, after it has been re-centred.

Re-centring happens after reset and whenever `realign_n` is held low. Re-centring places the read pointer a fixed distance behind the synchronized write pointer. While the buffer runs, the read side watches its view of the fill level. If the level reaches either limit, it raises a sticky error. Only the next re-centring clears that error.

The single `err` output is shared. In built-in self-test mode it instead carries a one-cycle pass pulse every 511 characters. Regardless of mode, it is forced high while both output enables are off (transmit PLL powered down) or while the reference clock has stopped. A free-running check clock detects the stopped reference.

Top module: `tx_phase_align_buf`

## Requirements
- R1: The 10-bit `din` is captured on the rising edge of the write clock. The write clock is `ext_clk` when `wclk_sel` = 0 and `ref_clk` when `wclk_sel` = 1. Characters then leave on `dout` in the order written, one per reference cycle.
- R2: When the external clock runs at the reference frequency with any fixed phase offset, every character appears on `dout` exactly once and in order, and `err` stays low.
- R3: Holding `realign_n` low re-centres the pointers and clears the sticky error. After release, `err` is low and ordered delivery resumes.
- R4: If the write clock runs faster than the reference clock, the buffer overflows. `err` then goes high and stays high after the clocks match again, until the next re-centring.
- R5: If the write clock runs slower than the reference clock, the buffer underflows. `err` then goes high and stays high until the next re-centring.
- R6: While `bist_en_n` = 0, `err` shows a pulse one reference cycle wide, with rising edges exactly 511 reference cycles apart. A pending sticky error is hidden in this mode and shows again once the mode ends.
- R7: When `oe_a` = 0 and `oe_b` = 0, `err` is high at once. When either enable is 1, the enables do not force `err`.
- R8: When `ref_clk` has shown no edge for 16 `chk_clk` cycles, `err` is high. Once the reference returns and the buffer is re-centred, `err` is low.
- R9: Asserting `rst_n` low asynchronously clears the output register (`dout` = 0) and the error state. After release, the block re-centres by itself and `err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock, also the internal character clock |
| ext_clk | input | 1 | External transmit interface clock |
| chk_clk | input | 1 | Free-running clock for reference-loss detection |
| wclk_sel | input | 1 | Write clock select: 0 = ext_clk, 1 = ref_clk |
| din | input | 10 | Transmit character input |
| realign_n | input | 1 | Re-centre request, active low |
| bist_en_n | input | 1 | Self-test progress mode, active low |
| oe_a | input | 1 | Output enable A |
| oe_b | input | 1 | Output enable B |
| dout | output | 10 | Character in the reference domain |
| err | output | 1 | Shared error / self-test / fault status |

## Verification
The bench runs the external clock at two phase offsets and also from the reference clock. In each case it checks that consecutive `dout` values step by exactly one. A read pointer centred wrongly, or a pointer sync that misses a step, would repeat or skip characters.

It pulls the write clock faster and then slower to force overflow and underflow. It then restores matched clocks and confirms that `err` stays high until re-centring. A design with a non-sticky flag would drop `err` as soon as the clocks match.

It measures the self-test pulse spacing and width while a sticky error is pending. A counter that is off by one would show a spacing of 510 or 512. A mux with the wrong priority would leave `err` stuck high.

It also stops the reference clock to check the fault indication, and turns off both output enables to check the forced-high case.

// File: rtl/pab_pkg.sv
package pab_pkg;

  typedef enum logic [0:0] {
    PAB_ALIGN = 1'b0,
    PAB_RUN   = 1'b1
  } pab_state_e;

endpackage

// File: rtl/pab_wr_side.sv
module pab_wr_side #(
  parameter int DW = 10,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   wgray
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [1:0]    wrst_q;
  logic          wrst_n;
  logic          wr_en;
  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q, wgray_d;
  logic [DW-1:0] mem_q [DEPTH];

  // reset: asserted at once, released on the write clock
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) wrst_q <= 2'b00;
    else        wrst_q <= {wrst_q[0], 1'b1};
  end
  assign wrst_n = wrst_q[1];
  assign wr_en  = wrst_n;

  always_comb begin
    wbin_d  = wbin_q + PW'(1);
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_en) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en) mem_q[wbin_q[AW-1:0]] <= din;
  end

  assign rd_data = mem_q[rd_idx];
  assign wgray   = wgray_q;

  AST_GRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_en |=> ($countones(wgray_q ^ $past(wgray_q)) == 1)); // R2

endmodule

// File: rtl/pab_rd_side.sv
module pab_rd_side
  import pab_pkg::*;
#(
  parameter int DW       = 10,
  parameter int AW       = 3,
  parameter int CENTER   = 3,
  parameter int BIST_LEN = 511
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          realign_n,
  input  logic          bist_en_n,
  input  logic [AW:0]   wgray,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_idx,
  output logic [DW-1:0] dout,
  output logic          sticky_err,
  output logic          bist_pulse,
  output logic          bist_on
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] OVF_LVL = PW'(DEPTH - 3);
  localparam logic [PW-1:0] CTR_OFS = PW'(CENTER);
  localparam int CW = $clog2(BIST_LEN);
  localparam logic [CW-1:0] LAST = CW'(BIST_LEN - 1);

  logic [1:0]    rrst_q;
  logic          rrst_n;
  logic [1:0]    align_q;
  logic          align_req;
  logic [1:0]    bist_q;
  logic [PW-1:0] ws1_q, ws2_q;
  logic [PW-1:0] wsync_bin;
  logic [PW-1:0] seen;
  logic [PW-1:0] rd_bin_q, rd_bin_d;
  pab_state_e    state_q, state_d;
  logic          err_q, err_d;
  logic [DW-1:0] dout_q;
  logic [CW-1:0] bcnt_q, bcnt_d;
  logic          bpulse_q, bpulse_d;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) rrst_q <= 2'b00;
    else        rrst_q <= {rrst_q[0], 1'b1};
  end
  assign rrst_n = rrst_q[1];

  // control synchronizers; a fresh reset counts as a re-centre request
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      align_q <= 2'b11;
      bist_q  <= 2'b00;
      ws1_q   <= '0;
      ws2_q   <= '0;
    end else begin
      align_q <= {align_q[0], ~realign_n};
      bist_q  <= {bist_q[0], ~bist_en_n};
      ws1_q   <= wgray;
      ws2_q   <= ws1_q;
    end
  end
  assign align_req = align_q[1];
  assign bist_on   = bist_q[1];

  always_comb begin
    for (int i = 0; i < PW; i++) wsync_bin[i] = ^(ws2_q >> i);
  end
  assign seen = wsync_bin - rd_bin_q;

  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    rd_bin_d = rd_bin_q;
    unique case (state_q)
      PAB_ALIGN: begin
        rd_bin_d = wsync_bin - CTR_OFS;
        err_d    = 1'b0;
        if (!align_req) state_d = PAB_RUN;
      end
      PAB_RUN: begin
        rd_bin_d = rd_bin_q + PW'(1);
        if (seen == '0 || seen >= OVF_LVL) err_d = 1'b1;
        if (align_req) state_d = PAB_ALIGN;
      end
      default: state_d = PAB_ALIGN;
    endcase
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      state_q  <= PAB_ALIGN;
      err_q    <= 1'b0;
      rd_bin_q <= '0;
      dout_q   <= '0;
    end else begin
      state_q  <= state_d;
      err_q    <= err_d;
      rd_bin_q <= rd_bin_d;
      dout_q   <= rd_data;
    end
  end

  // self-test progress tick
  always_comb begin
    bcnt_d   = '0;
    bpulse_d = 1'b0;
    if (bist_on) begin
      bcnt_d   = (bcnt_q == LAST) ? '0 : bcnt_q + CW'(1);
      bpulse_d = (bcnt_q == LAST);
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      bcnt_q   <= '0;
      bpulse_q <= 1'b0;
    end else begin
      bcnt_q   <= bcnt_d;
      bpulse_q <= bpulse_d;
    end
  end

  assign rd_idx     = rd_bin_q[AW-1:0];
  assign dout       = dout_q;
  assign sticky_err = err_q;
  assign bist_pulse = bpulse_q;

  AST_ERR_STICKY: assert property (@(posedge rclk) disable iff (!rrst_n)
    (state_q == PAB_RUN && err_q) |=> err_q); // R4
  AST_ALIGN_CLEARS: assert property (@(posedge rclk) disable iff (!rrst_n)
    (state_q == PAB_ALIGN) |=> !err_q); // R3
  AST_BIST_ONE_WIDE: assert property (@(posedge rclk) disable iff (!rrst_n)
    bpulse_q |=> !bpulse_q); // R6

endmodule

// File: rtl/pab_ref_mon.sv
module pab_ref_mon #(
  parameter int LIMIT = 16
) (
  input  logic ref_clk,
  input  logic chk_clk,
  input  logic rst_n,
  output logic ref_lost
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [1:0]    frst_q;
  logic          frst_n;
  logic          tog_q;
  logic [1:0]    crst_q;
  logic          crst_n;
  logic [2:0]    ts_q;
  logic          edge_seen;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lost_q, lost_d;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) frst_q <= 2'b00;
    else        frst_q <= {frst_q[0], 1'b1};
  end
  assign frst_n = frst_q[1];

  always_ff @(posedge ref_clk or negedge frst_n) begin
    if (!frst_n) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) crst_q <= 2'b00;
    else        crst_q <= {crst_q[0], 1'b1};
  end
  assign crst_n = crst_q[1];

  always_ff @(posedge chk_clk or negedge crst_n) begin
    if (!crst_n) ts_q <= '0;
    else         ts_q <= {ts_q[1:0], tog_q};
  end
  assign edge_seen = ts_q[1] ^ ts_q[2];

  always_comb begin
    if (edge_seen)        cnt_d = '0;
    else if (cnt_q < LIM) cnt_d = cnt_q + CW'(1);
    else                  cnt_d = cnt_q;
    lost_d = (cnt_d == LIM);
  end

  always_ff @(posedge chk_clk or negedge crst_n) begin
    if (!crst_n) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign ref_lost = lost_q;

  AST_EDGE_CLEARS_LOST: assert property (@(posedge chk_clk) disable iff (!crst_n)
    edge_seen |=> !lost_q); // R8
  AST_LOST_NEEDS_QUIET: assert property (@(posedge chk_clk) disable iff (!crst_n)
    $rose(lost_q) |-> !$past(edge_seen)); // R8

endmodule

// File: rtl/tx_phase_align_buf.sv
module tx_phase_align_buf #(
  parameter int DW        = 10,
  parameter int AW        = 3,
  parameter int CENTER    = 3,
  parameter int BIST_LEN  = 511,
  parameter int REF_LIMIT = 16
) (
  input  logic          rst_n,
  input  logic          ref_clk,
  input  logic          ext_clk,
  input  logic          chk_clk,
  input  logic          wclk_sel,
  input  logic [DW-1:0] din,
  input  logic          realign_n,
  input  logic          bist_en_n,
  input  logic          oe_a,
  input  logic          oe_b,
  output logic [DW-1:0] dout,
  output logic          err
);
  logic          wclk;
  logic [AW:0]   wgray;
  logic [AW-1:0] rd_idx;
  logic [DW-1:0] rd_data;
  logic          sticky_err;
  logic          bist_pulse;
  logic          bist_on;
  logic          ref_lost;
  logic          pll_down;

  assign wclk = wclk_sel ? ref_clk : ext_clk;

  pab_wr_side #(.DW(DW), .AW(AW)) i_wr (
    .wclk    (wclk),
    .rst_n   (rst_n),
    .din     (din),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wgray   (wgray)
  );

  pab_rd_side #(.DW(DW), .AW(AW), .CENTER(CENTER), .BIST_LEN(BIST_LEN)) i_rd (
    .rclk       (ref_clk),
    .rst_n      (rst_n),
    .realign_n  (realign_n),
    .bist_en_n  (bist_en_n),
    .wgray      (wgray),
    .rd_data    (rd_data),
    .rd_idx     (rd_idx),
    .dout       (dout),
    .sticky_err (sticky_err),
    .bist_pulse (bist_pulse),
    .bist_on    (bist_on)
  );

  pab_ref_mon #(.LIMIT(REF_LIMIT)) i_mon (
    .ref_clk  (ref_clk),
    .chk_clk  (chk_clk),
    .rst_n    (rst_n),
    .ref_lost (ref_lost)
  );

  assign pll_down = ~oe_a & ~oe_b;
  assign err      = pll_down | ref_lost | (bist_on ? bist_pulse : sticky_err);

endmodule

// File: tb/test_tx_phase_align_buf.sv
module test_tx_phase_align_buf;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int CHK_HALF   = 3;

  logic       rst_n, ref_src, ref_run, ref_clk, chk_clk;
  logic       ext_lock, ext_free, use_free, ext_clk, bwclk;
  logic       wclk_sel, realign_n, bist_en_n, oe_a, oe_b;
  logic [9:0] din, dout;
  logic       err;
  int         ext_ofs, free_half;
  int         checks, errors;
  bit         done;

  tx_phase_align_buf i_tx_phase_align_buf (
    .rst_n(rst_n), .ref_clk(ref_clk), .ext_clk(ext_clk), .chk_clk(chk_clk),
    .wclk_sel(wclk_sel), .din(din), .realign_n(realign_n), .bist_en_n(bist_en_n),
    .oe_a(oe_a), .oe_b(oe_b), .dout(dout), .err(err)
  );

  initial begin ref_src = 1'b0; forever #(HALF) ref_src = ~ref_src; end
  initial begin chk_clk = 1'b0; forever #(CHK_HALF) chk_clk = ~chk_clk; end
  initial begin
    ext_lock = 1'b0;
    forever begin
      @(posedge ref_src);
      #(ext_ofs);
      ext_lock = 1'b1;
      #(HALF);
      ext_lock = 1'b0;
    end
  end
  initial begin ext_free = 1'b0; #1; forever begin #(free_half); ext_free = ~ext_free; end end

  assign ref_clk = ref_src & ref_run;
  assign ext_clk = use_free ? ext_free : ext_lock;
  assign bwclk   = wclk_sel ? ref_clk : ext_clk;

  initial begin
    din = '0;
    forever begin @(negedge bwclk); din = din + 10'd1; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge ref_src);
  endtask

  task automatic realign();
    realign_n = 1'b0;
    cycles(6);
    realign_n = 1'b1;
    cycles(20);
  endtask

  task automatic order_run(input string req, input int n);
    int bad = 0;
    int first_act = 0, first_exp = 0;
    logic [9:0] prev;
    @(negedge ref_src);
    prev = dout;
    for (int i = 0; i < n; i++) begin
      @(negedge ref_src);
      if (dout != prev + 10'd1) begin
        if (bad == 0) begin first_act = int'(dout); first_exp = int'(prev + 10'd1); end
        bad++;
      end
      prev = dout;
    end
    check(bad == 0, req, first_act, first_exp);
    check(err == 1'b0, req, int'(err), 0);
  endtask

  task automatic t_reset();
    cycles(5);
    check(dout == 10'd0, "R9 dout during reset", int'(dout), 0);
    check(err == 1'b0, "R9 err during reset", int'(err), 0);
    rst_n = 1'b1;
    cycles(40);
    check(err == 1'b0, "R9 err after reset", int'(err), 0);
  endtask

  task automatic t_ext_phase();
    ext_ofs = 1; realign();
    order_run("R2 ext clock offset 1ns", 150);
    ext_ofs = 4; realign();
    order_run("R2 ext clock offset 4ns", 150);
    order_run("R1 ext clock capture", 50);
  endtask

  task automatic t_ref_sel();
    wclk_sel = 1'b1; realign();
    order_run("R1 reference clock writes", 150);
    wclk_sel = 1'b0; realign();
    order_run("R1 back to ext clock", 50);
  endtask

  task automatic t_overflow();
    free_half = 4; use_free = 1'b1;
    cycles(60);
    check(err == 1'b1, "R4 overflow sets err", int'(err), 1);
    use_free = 1'b0;
    cycles(100);
    check(err == 1'b1, "R4 err sticky after clocks match", int'(err), 1);
    realign();
    check(err == 1'b0, "R3 realign clears err", int'(err), 0);
    order_run("R3 ordered after realign", 100);
  endtask

  task automatic t_underflow_bist();
    int rise_gap = 0;
    int seen_rise = 0;
    bit prev_err;
    free_half = 6; use_free = 1'b1;
    cycles(60);
    check(err == 1'b1, "R5 underflow sets err", int'(err), 1);
    use_free = 1'b0;
    cycles(50);
    check(err == 1'b1, "R5 err sticky", int'(err), 1);
    bist_en_n = 1'b0;
    cycles(5);
    check(err == 1'b0, "R6 sticky hidden in self-test", int'(err), 0);
    prev_err = err;
    for (int i = 0; i < 1300 && seen_rise < 2; i++) begin
      @(negedge ref_src);
      if (seen_rise == 1) rise_gap++;
      if (err && !prev_err) begin
        seen_rise++;
        if (seen_rise == 1) begin
          @(negedge ref_src);
          rise_gap = 1;
          check(err == 1'b0, "R6 pulse one cycle wide", int'(err), 0);
        end
      end
      prev_err = err;
    end
    check(seen_rise == 2, "R6 two pulses seen", seen_rise, 2);
    check(rise_gap == 511, "R6 pulse spacing", rise_gap, 511);
    bist_en_n = 1'b1;
    cycles(5);
    check(err == 1'b1, "R6 sticky returns after self-test", int'(err), 1);
    realign();
    check(err == 1'b0, "R3 realign after underflow", int'(err), 0);
  endtask

  task automatic t_power();
    oe_a = 1'b0; oe_b = 1'b0; #1;
    check(err == 1'b1, "R7 both enables off", int'(err), 1);
    oe_b = 1'b1; #1;
    check(err == 1'b0, "R7 one enable on", int'(err), 0);
    oe_a = 1'b1; oe_b = 1'b0; #1;
    check(err == 1'b0, "R7 other enable on", int'(err), 0);
    oe_b = 1'b1;
    cycles(2);
  endtask

  task automatic t_ref_missing();
    @(negedge ref_src);
    ref_run = 1'b0;
    #(400);
    check(err == 1'b1, "R8 reference stopped", int'(err), 1);
    @(negedge ref_src);
    ref_run = 1'b1;
    cycles(10);
    realign();
    check(err == 1'b0, "R8 reference restored", int'(err), 0);
    order_run("R8 ordered after restore", 50);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; ref_run = 1'b1; use_free = 1'b0;
    ext_ofs = 1; free_half = 4; wclk_sel = 1'b0;
    realign_n = 1'b1; bist_en_n = 1'b1; oe_a = 1'b1; oe_b = 1'b1;
    t_reset();
    t_ext_phase();
    t_ref_sel();
    t_overflow();
    t_underflow_bist();
    t_power();
    t_ref_missing();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule